// File: doc/BRIEF.md
# Channel-Tagged Mailbox

This block passes 32-bit messages both ways between a processor and a coprocessor. Each message keeps a 4-bit channel number in bits [3:0] and a 28-bit payload in bits [31:4]. The block does not read or change either field. Each direction has its own first-in first-out queue. The depth is a parameter and defaults to 8 words.

The processor uses a small register port with four word addresses. It writes outbound messages to one data register and reads inbound messages from another. Each direction also has a status register that shows whether that queue is full or empty. The processor is expected to check the status before it touches a data register. A reader that wants one channel reads words, drops any whose channel field does not match, and reads again.

The coprocessor uses two valid/ready streams. One stream presents the head of the outbound queue. The other accepts words into the inbound queue.

Top module: `chan_mailbox`

## Requirements
- R1: After reset, both queues are empty. Both status registers read 0x4000_0000: bit 30 (empty) is 1, bit 31 (full) is 0 and bit 0 is 0. `co_out_valid` is 0 and `co_in_ready` is 1.
- R2: A processor write to address 2 queues the word unchanged. The coprocessor then receives it on `co_out_data`, with the channel still in bits [3:0] and the payload in bits [31:4].
- R3: The outbound status register at address 3 sets bit 31 exactly when the queue holds DEPTH words, and sets bit 30 exactly when the queue holds none.
- R4: A write to address 2 while the outbound queue is full is dropped and sets the sticky bit 0 of address 3. That bit stays set until the processor writes a 1 to bit 0 of address 3.
- R5: The coprocessor inbound stream takes a word on every clock edge where `co_in_valid` and `co_in_ready` are both high. `co_in_ready` is low while the inbound queue holds DEPTH words, and a word offered then is lost.
- R6: The inbound status register at address 1 sets bit 31 exactly when the inbound queue is full and bit 30 exactly when it is empty. All other bits read 0.
- R7: A read of address 0 returns the oldest inbound word and removes it from the queue. A read of address 0 while the inbound queue is empty returns 0 and removes nothing.
- R8: Both queues deliver words in arrival order and hold up to DEPTH words each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 2 | Word address: 0 inbound data, 1 inbound status, 2 outbound data, 3 outbound status |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| co_out_valid | output | 1 | Outbound queue has a word |
| co_out_ready | input | 1 | Coprocessor takes the outbound word |
| co_out_data | output | 32 | Oldest outbound word |
| co_in_valid | input | 1 | Coprocessor offers a word |
| co_in_ready | output | 1 | Inbound queue has room |
| co_in_data | input | 32 | Offered word |

## Verification
The hardest situation to reach is a processor write that lands on a full outbound queue. At the same time, the test must show that the queued words are still intact and that the dropped word never appears. The bench fills the queue with nine writes while `co_out_ready` is held low. It then reads the status to find the overflow bit, and drains the queue to confirm that exactly eight words come out in order. The inbound side is driven the same way. The coprocessor offers nine words against a stalled processor, and reads past the empty point must return zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MSG_W  = 32;
    localparam int CHAN_W = 4;
    localparam int PAY_W  = MSG_W - CHAN_W;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int STAT_OVF_BIT   = 0;

    typedef struct packed {
        logic [PAY_W-1:0]  payload;
        logic [CHAN_W-1:0] chan;
    } mbx_msg_t;

    typedef enum logic [1:0] {
        REG_IN_DATA  = 2'd0,
        REG_IN_STAT  = 2'd1,
        REG_OUT_DATA = 2'd2,
        REG_OUT_STAT = 2'd3
    } mbx_reg_e;

    function automatic logic [MSG_W-1:0] pack_status(input logic full,
                                                     input logic empty,
                                                     input logic ovf);
        logic [MSG_W-1:0] s;
        s = '0;
        s[STAT_FULL_BIT]  = full;
        s[STAT_EMPTY_BIT] = empty;
        s[STAT_OVF_BIT]   = ovf;
        return s;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && count == $past(count))); // R4
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(count)); // R8

endmodule

// File: rtl/mbx_cpu_if.sv
module mbx_cpu_if
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_sel,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_addr,
    input  logic [MSG_W-1:0] cpu_wdata,
    output logic [MSG_W-1:0] cpu_rdata,
    input  logic [MSG_W-1:0] in_head,
    input  logic             in_full,
    input  logic             in_empty,
    output logic             in_pop,
    input  logic             out_full,
    input  logic             out_empty,
    output logic             out_push
);
    mbx_reg_e reg_sel;
    logic     ovf, ovf_clr;

    assign reg_sel  = mbx_reg_e'(cpu_addr);
    assign in_pop   = cpu_sel && !cpu_we && (reg_sel == REG_IN_DATA) && !in_empty;
    assign out_push = cpu_sel && cpu_we && (reg_sel == REG_OUT_DATA);
    assign ovf_clr  = cpu_sel && cpu_we && (reg_sel == REG_OUT_STAT)
                      && cpu_wdata[STAT_OVF_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (out_push && out_full) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel && !cpu_we) begin
            case (reg_sel)
                REG_IN_DATA:  cpu_rdata = in_empty ? '0 : in_head;
                REG_IN_STAT:  cpu_rdata = pack_status(in_full, in_empty, 1'b0);
                REG_OUT_STAT: cpu_rdata = pack_status(out_full, out_empty, ovf);
                default:      cpu_rdata = '0;
            endcase
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (out_push && out_full) |=> ovf); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf); // R4

endmodule

// File: rtl/chan_mailbox.sv
module chan_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_sel,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        co_out_valid,
    input  logic        co_out_ready,
    output logic [31:0] co_out_data,
    input  logic        co_in_valid,
    output logic        co_in_ready,
    input  logic [31:0] co_in_data
);
    mbx_msg_t out_head, in_head, out_word, in_word;
    logic     out_full, out_empty, out_push;
    logic     in_full, in_empty, in_pop;

    assign out_word     = mbx_msg_t'(cpu_wdata);
    assign in_word      = mbx_msg_t'(co_in_data);
    assign co_out_valid = !out_empty;
    assign co_out_data  = out_head;
    assign co_in_ready  = !in_full;

    mbx_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_out_q (
        .clk(clk), .rst(rst),
        .push(out_push), .push_data(out_word),
        .pop(co_out_ready), .head(out_head),
        .full(out_full), .empty(out_empty)
    );

    mbx_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_in_q (
        .clk(clk), .rst(rst),
        .push(co_in_valid), .push_data(in_word),
        .pop(in_pop), .head(in_head),
        .full(in_full), .empty(in_empty)
    );

    mbx_cpu_if u_cpu (
        .clk(clk), .rst(rst),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .in_head(in_head), .in_full(in_full), .in_empty(in_empty), .in_pop(in_pop),
        .out_full(out_full), .out_empty(out_empty), .out_push(out_push)
    );

    AST_IN_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        (!co_in_ready && co_in_valid && !in_pop) |=> !co_in_ready); // R5
    AST_OUT_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (co_out_valid && !co_out_ready) |=> (co_out_valid && $stable(co_out_data))); // R8

endmodule

// File: tb/chan_mailbox_bench.sv
module chan_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_sel = 0, cpu_we = 0;
    logic [1:0]  cpu_addr = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        co_out_valid, co_out_ready = 0;
    logic [31:0] co_out_data;
    logic        co_in_valid = 0, co_in_ready;
    logic [31:0] co_in_data = 0;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    chan_mailbox u_chan_mailbox (
        .clk(clk), .rst(rst),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .co_out_valid(co_out_valid), .co_out_ready(co_out_ready), .co_out_data(co_out_data),
        .co_in_valid(co_in_valid), .co_in_ready(co_in_ready), .co_in_data(co_in_data)
    );

    function automatic logic [31:0] msg(input int n, input logic [3:0] ch);
        return {28'(32'hA5000 + n * 17), ch};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 0;
    endtask

    task automatic co_take(output logic [31:0] d, output logic v);
        @(negedge clk);
        v = co_out_valid; d = co_out_data;
        co_out_ready = 1;
        @(negedge clk);
        co_out_ready = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 out_valid", {31'd0, co_out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, co_in_ready}, 32'd1);
        bus_read(2'd1, d); check("R1/R6 in status", d, 32'h4000_0000);
        bus_read(2'd3, d); check("R1/R3 out status", d, 32'h4000_0000);
    endtask

    task automatic t_out_basic;
        logic [31:0] d; logic v;
        for (int i = 0; i < 3; i++) bus_write(2'd2, msg(i, 4'(i + 8)));
        for (int i = 0; i < 3; i++) begin
            co_take(d, v);
            check("R2 out valid", {31'd0, v}, 32'd1);
            check("R2 out word", d, msg(i, 4'(i + 8)));
        end
        check("R8 out drained", {31'd0, co_out_valid}, 32'd0);
    endtask

    task automatic t_out_overflow;
        logic [31:0] d; logic v;
        for (int i = 0; i < 8; i++) bus_write(2'd2, msg(i + 20, 4'(i)));
        bus_read(2'd3, d); check("R3 out full", d, 32'h8000_0000);
        bus_write(2'd2, 32'hDEAD_BEEF);
        bus_read(2'd3, d); check("R4 ovf set", d, 32'h8000_0001);
        for (int i = 0; i < 8; i++) begin
            co_take(d, v);
            check("R8 out order", d, msg(i + 20, 4'(i)));
        end
        check("R4 dropped absent", {31'd0, co_out_valid}, 32'd0);
        bus_read(2'd3, d); check("R4 ovf sticky", d, 32'h4000_0001);
        bus_write(2'd3, 32'h1);
        bus_read(2'd3, d); check("R4 ovf cleared", d, 32'h4000_0000);
    endtask

    task automatic t_in_path;
        logic [31:0] d;
        bus_read(2'd0, d); check("R7 empty read zero", d, 32'd0);
        bus_read(2'd1, d); check("R7 empty still", d, 32'h4000_0000);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            co_in_valid = 1; co_in_data = msg(i + 40, 4'(15 - i));
            if (i == 8) check("R5 ready low when full", {31'd0, co_in_ready}, 32'd0);
        end
        @(negedge clk); co_in_valid = 0;
        bus_read(2'd1, d); check("R6 in full", d, 32'h8000_0000);
        for (int i = 0; i < 8; i++) begin
            bus_read(2'd0, d);
            check("R7/R8 in order", d, msg(i + 40, 4'(15 - i)));
        end
        bus_read(2'd1, d); check("R5 extra word lost", d, 32'h4000_0000);
        bus_read(2'd0, d); check("R7 read past empty", d, 32'd0);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_out_basic;
        t_out_overflow;
        t_in_path;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule